// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Arming Controller

This block runs the receive side of a USB device core for bulk OUT endpoints 1 to 7. For each OUT token it decides whether the following data packet is stored or thrown away. It returns an ACK or NAK handshake, or none at all when the packet arrived corrupted. Each endpoint carries a busy flag, which means the endpoint is armed and owned by the USB side, and an interrupt request. A good packet clears the busy flag and sets the interrupt request. The CPU re-arms an endpoint by writing any value to that endpoint's byte-count register.

A pairing register can join each neighbouring even/odd OUT endpoint pair (2/3, 4/5, 6/7) into one double-buffered endpoint. The CPU then works only through the even endpoint number. The serial engine fills the two buffers in turn, starting with the even one. Each byte-count write hands the older full buffer back to the USB side. Serial encoding, CRC computation and the packet RAM are outside this block. The block only tells the engine whether to store a packet, and which endpoint buffer it goes into.

The transaction state machine has four states:
- `ST_IDLE` waits for a token. It moves to `ST_RECV` on an OUT token for an armed endpoint and to `ST_DROP` on a token for an unarmed one. A token for endpoint 0 leaves it in `ST_IDLE`.
- `ST_RECV` and `ST_DROP` both move to `ST_HAND` when the packet ends.
- `ST_HAND` sends the handshake and returns to `ST_IDLE`.
- A USB bus reset forces `ST_IDLE` from every state.

Top module: `usb_out_arm_ctrl`

## Requirements
- R1: After device reset or a one-cycle `bus_reset`, endpoints 1 to 7 read busy=1 and interrupt=0. Bit 0 of `ep_busy` and `ep_irq` always reads 0.
- R2: An OUT token for an endpoint that is not armed keeps `store_en` at 0 for the whole packet. A good packet then gets NAK, and a corrupted one gets no handshake.
- R3: An OUT token for an armed endpoint raises `store_en`, with `store_ep` equal to that endpoint, until the packet ends. A good packet (CRC and toggle both correct) gets ACK, clears the endpoint's busy bit and sets its interrupt bit. Handshake codes are 0 none, 1 ACK, 2 NAK.
- R4: After a packet is accepted, further tokens to that endpoint get NAK until the CPU writes any value to its byte-count register (`cpu_sel`=0, `cpu_ep`=endpoint). That write sets busy again.
- R5: A packet with a CRC error or a toggle mismatch gets no handshake and leaves the busy and interrupt bits unchanged.
- R6: Writing the interrupt-clear register (`cpu_sel`=1) clears each interrupt bit whose `cpu_wdata` bit (bit n = endpoint n) is 1. Bits written as 0 leave their interrupt bit unchanged.
- R7: The pairing register (`cpu_sel`=2, `cpu_wdata[5:0]`) is read on `pair_cfg`. Bits 0 to 2 pair the IN endpoints 2/3, 4/5, 6/7; they are only stored here. Bits 3 to 5 pair the OUT endpoints 2/3, 4/5, 6/7. Changing an OUT bit returns that pair to the reset state: both endpoints busy, both interrupts clear.
- R8: In a paired OUT endpoint, accepted packets go alternately to buffer `store_ep`=even and `store_ep`=odd, starting with the even one. Every accepted packet sets the even endpoint's interrupt. The even endpoint's busy reads 1 while a buffer is free and 0 when both are full.
- R9: In a paired OUT endpoint, a byte-count write to the even endpoint frees the older full buffer. Byte-count writes to the odd endpoint are ignored, tokens to the odd endpoint get NAK, and the odd endpoint's busy and interrupt read 0.
- R10: An OUT token for endpoint 0 gets no handshake and no store, and a byte-count write to endpoint 0 has no effect.
- R11: The handshake appears on `hs_valid`/`hs_code` for exactly one cycle, in the cycle after the cycle where `pkt_end` is high.
- R12: A USB bus reset leaves the pairing register unchanged. The pairing register changes only through a pairing-register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| bus_reset | input | 1 | USB bus reset seen on the wire, one-cycle pulse |
| tok_valid | input | 1 | OUT token received this cycle |
| tok_ep | input | 3 | Endpoint number of the token |
| pkt_end | input | 1 | Data packet finished this cycle |
| crc_ok | input | 1 | Packet CRC correct, valid with pkt_end |
| tog_ok | input | 1 | Data toggle matched, valid with pkt_end |
| store_en | output | 1 | Engine may write packet bytes to the buffer |
| store_ep | output | 3 | Endpoint buffer that receives the bytes |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_sel | input | 2 | 0 byte count, 1 interrupt clear, 2 pairing |
| cpu_ep | input | 3 | Endpoint addressed by a byte-count write |
| cpu_wdata | input | 8 | Write data |
| ep_busy | output | 8 | Per-endpoint busy (armed) bits |
| ep_irq | output | 8 | Per-endpoint interrupt requests |
| pair_cfg | output | 6 | Pairing register contents |

## Verification
The assertions check every cycle that:
- an ACK only follows a stored packet, and a NAK only follows a discarded one;
- the handshake lasts a single cycle right after packet end;
- a good unpaired packet clears busy and sets the interrupt;
- a byte-count write re-arms the endpoint;
- a slot clear empties the interrupts;
- the pairing register never changes without a write.

Only the bench scenarios can show the longer behaviour:
- the ping-pong order of the paired buffers, and which buffer each byte-count write frees;
- NAK continuing across many tokens until a re-arm;
- corrupted packets leaving state untouched;
- the pairing register surviving a bus reset.

// File: rtl/usb_out_arm_pkg.sv
package usb_out_arm_pkg;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_HAND
    } arm_state_e;

    typedef enum logic [1:0] {
        REG_BCNT   = 2'd0,
        REG_IRQCLR = 2'd1,
        REG_PAIR   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/usb_out_arm_fsm.sv
module usb_out_arm_fsm
    import usb_out_arm_pkg::*;
#(
    parameter int EP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            tok_valid,
    input  logic [EP_W-1:0] tok_ep,
    input  logic            pkt_end,
    input  logic            crc_ok,
    input  logic            tog_ok,
    input  logic            ep_ready,
    input  logic [EP_W-1:0] tgt_ep,
    output logic            store_en,
    output logic [EP_W-1:0] store_ep,
    output logic            hs_valid,
    output logic [1:0]      hs_code,
    output logic            commit_v,
    output logic [EP_W-1:0] commit_ep
);

    arm_state_e      state_q, state_d;
    hs_code_e        hs_q, hs_d;
    logic [EP_W-1:0] log_q;
    logic [EP_W-1:0] phy_q;
    logic            pkt_good;

    assign pkt_good = crc_ok && tog_ok;

    // Next-state and pending handshake.
    always_comb begin
        state_d = state_q;
        hs_d    = hs_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_valid && (tok_ep != '0)) begin
                    state_d = ep_ready ? ST_RECV : ST_DROP;
                end
            end
            ST_RECV: begin
                if (pkt_end) begin
                    state_d = ST_HAND;
                    hs_d    = pkt_good ? HS_ACK : HS_NONE;
                end
            end
            ST_DROP: begin
                if (pkt_end) begin
                    state_d = ST_HAND;
                    hs_d    = pkt_good ? HS_NAK : HS_NONE;
                end
            end
            ST_HAND: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (bus_reset) begin
            state_d = ST_IDLE;
        end
    end

    // State register and latched token data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hs_q    <= HS_NONE;
            log_q   <= '0;
            phy_q   <= '0;
        end else begin
            state_q <= state_d;
            hs_q    <= hs_d;
            if ((state_q == ST_IDLE) && tok_valid) begin
                log_q <= tok_ep;
                phy_q <= tgt_ep;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        store_en  = (state_q == ST_RECV);
        store_ep  = phy_q;
        hs_valid  = (state_q == ST_HAND) && (hs_q != HS_NONE);
        hs_code   = (state_q == ST_HAND) ? hs_q : HS_NONE;
        commit_v  = (state_q == ST_RECV) && pkt_end && pkt_good && !bus_reset;
        commit_ep = log_q;
    end

    // R3: an ACK is only sent for a packet that was being stored
    assert_ack_needs_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_ACK) |-> $past(store_en));

    // R2: a NAK is only sent for a packet that was being discarded
    assert_nak_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_NAK) |-> !$past(store_en));

    // R11: a handshake follows packet end directly
    assert_hs_after_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(pkt_end));

    // R11: the handshake lasts one cycle
    assert_hs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R10: a token for endpoint 0 starts no transaction
    assert_ep0_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tok_valid && tok_ep == '0) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/usb_out_arm_slot.sv
module usb_out_arm_slot #(
    parameter bit LO_EN    = 1'b1,
    parameter bit PAIRABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       pair_en,
    input  logic       commit_v,
    input  logic       commit_hi,
    input  logic       bc_v,
    input  logic       bc_hi,
    input  logic [1:0] irq_clr,
    output logic [1:0] ready,
    output logic       fill_hi,
    output logic [1:0] busy,
    output logic [1:0] irq
);

    localparam logic [1:0] LANE_MASK = {1'b1, LO_EN};

    logic [1:0] own_q, own_d;
    logic [1:0] irq_q, irq_d;
    logic       fp_q, fp_d;
    logic       dp_q, dp_d;
    logic       paired;

    assign paired = PAIRABLE && pair_en;

    always_comb begin
        own_d = own_q;
        fp_d  = fp_q;
        dp_d  = dp_q;
        irq_d = irq_q & ~irq_clr;
        if (commit_v) begin
            if (paired) begin
                own_d[fp_q] = 1'b0;
                fp_d        = ~fp_q;
                irq_d[0]    = 1'b1;
            end else begin
                own_d[commit_hi] = 1'b0;
                irq_d[commit_hi] = 1'b1;
            end
        end
        if (bc_v) begin
            if (paired) begin
                if (!bc_hi && !own_q[dp_q]) begin
                    own_d[dp_q] = 1'b1;
                    dp_d        = ~dp_q;
                end
            end else begin
                own_d[bc_hi] = 1'b1;
            end
        end
        own_d = own_d & LANE_MASK;
        irq_d = irq_d & LANE_MASK;
        if (clr) begin
            own_d = LANE_MASK;
            fp_d  = 1'b0;
            dp_d  = 1'b0;
            irq_d = 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= LANE_MASK;
            irq_q <= 2'b00;
            fp_q  <= 1'b0;
            dp_q  <= 1'b0;
        end else begin
            own_q <= own_d;
            irq_q <= irq_d;
            fp_q  <= fp_d;
            dp_q  <= dp_d;
        end
    end

    assign ready   = paired ? {1'b0, own_q[fp_q]} : own_q;
    assign fill_hi = paired ? fp_q : 1'b0;
    assign busy    = ready;
    assign irq     = irq_q;

    // R3: a good packet on an unpaired endpoint clears busy and raises the interrupt
    assert_good_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_v && !paired && !clr && !bc_v) |=>
            (!busy[$past(commit_hi)] && irq[$past(commit_hi)]));

    // R4: a byte-count write re-arms an unpaired, enabled endpoint
    assert_bc_rearms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_v && !paired && !clr && (bc_hi || LO_EN)) |=> busy[$past(bc_hi)]);

    // R7: clearing a slot drops both interrupt requests
    assert_clr_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (irq == 2'b00));

    // R9: the odd half of a pair never raises an interrupt
    assert_pair_odd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        paired |-> !irq_q[1]);

    // R8: a paired packet always signals through the even endpoint
    assert_pair_irq_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (paired && commit_v && !clr) |=> irq[0]);

endmodule

// File: rtl/usb_out_arm_cfg.sv
module usb_out_arm_cfg #(
    parameter  int NUM_SLOT = 4,
    localparam int PAIR_W   = 2 * (NUM_SLOT - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_v,
    input  logic [PAIR_W-1:0]   wr_data,
    output logic [PAIR_W-1:0]   pair_q,
    output logic [NUM_SLOT-1:0] pair_en,
    output logic [NUM_SLOT-1:0] chg
);

    localparam int OUT_BASE = NUM_SLOT - 1;

    logic [PAIR_W-1:0] pair_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_r <= '0;
        end else if (wr_v) begin
            pair_r <= wr_data;
        end
    end

    assign pair_q = pair_r;

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot_cfg
        if (k == 0) begin : g_fixed
            assign pair_en[k] = 1'b0;
            assign chg[k]     = 1'b0;
        end else begin : g_out
            assign pair_en[k] = pair_r[OUT_BASE+k-1];
            assign chg[k]     = wr_v && (wr_data[OUT_BASE+k-1] != pair_r[OUT_BASE+k-1]);
        end
    end

    // R12: pairing changes only through a write
    assert_pair_only_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_v |=> $stable(pair_r));

endmodule

// File: rtl/usb_out_arm_ctrl.sv
module usb_out_arm_ctrl
    import usb_out_arm_pkg::*;
#(
    parameter  int EP_W     = 3,
    localparam int NUM_EP   = 1 << EP_W,
    localparam int NUM_SLOT = NUM_EP / 2,
    localparam int PAIR_W   = 2 * (NUM_SLOT - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              pkt_end,
    input  logic              crc_ok,
    input  logic              tog_ok,
    output logic              store_en,
    output logic [EP_W-1:0]   store_ep,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [EP_W-1:0]   cpu_ep,
    input  logic [NUM_EP-1:0] cpu_wdata,
    output logic [NUM_EP-1:0] ep_busy,
    output logic [NUM_EP-1:0] ep_irq,
    output logic [PAIR_W-1:0] pair_cfg
);

    localparam int SLOT_W = EP_W - 1;

    logic [NUM_EP-1:0]   ready_flat;
    logic [NUM_SLOT-1:0] fill_flat;
    logic [NUM_SLOT-1:0] pair_en;
    logic [NUM_SLOT-1:0] pair_chg;
    logic [SLOT_W-1:0]   tok_slot;
    logic                ep_ready;
    logic [EP_W-1:0]     tgt_ep;
    logic                commit_v;
    logic [EP_W-1:0]     commit_ep;
    logic                bc_we;
    logic                irq_we;
    logic                pair_we;

    assign tok_slot = tok_ep[EP_W-1:1];
    assign ep_ready = ready_flat[tok_ep];
    assign tgt_ep   = {tok_slot, pair_en[tok_slot] ? fill_flat[tok_slot] : tok_ep[0]};

    assign bc_we   = cpu_we && (cpu_sel == REG_BCNT);
    assign irq_we  = cpu_we && (cpu_sel == REG_IRQCLR);
    assign pair_we = cpu_we && (cpu_sel == REG_PAIR);

    usb_out_arm_fsm #(
        .EP_W (EP_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .tok_valid (tok_valid),
        .tok_ep    (tok_ep),
        .pkt_end   (pkt_end),
        .crc_ok    (crc_ok),
        .tog_ok    (tog_ok),
        .ep_ready  (ep_ready),
        .tgt_ep    (tgt_ep),
        .store_en  (store_en),
        .store_ep  (store_ep),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .commit_v  (commit_v),
        .commit_ep (commit_ep)
    );

    usb_out_arm_cfg #(
        .NUM_SLOT (NUM_SLOT)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_v    (pair_we),
        .wr_data (cpu_wdata[PAIR_W-1:0]),
        .pair_q  (pair_cfg),
        .pair_en (pair_en),
        .chg     (pair_chg)
    );

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
        localparam bit HAS_LO = (k != 0);

        usb_out_arm_slot #(
            .LO_EN    (HAS_LO),
            .PAIRABLE (HAS_LO)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (bus_reset || pair_chg[k]),
            .pair_en   (pair_en[k]),
            .commit_v  (commit_v && (commit_ep[EP_W-1:1] == SLOT_W'(k))),
            .commit_hi (commit_ep[0]),
            .bc_v      (bc_we && (cpu_ep[EP_W-1:1] == SLOT_W'(k))),
            .bc_hi     (cpu_ep[0]),
            .irq_clr   (irq_we ? cpu_wdata[2*k +: 2] : 2'b00),
            .ready     (ready_flat[2*k +: 2]),
            .fill_hi   (fill_flat[k]),
            .busy      (ep_busy[2*k +: 2]),
            .irq       (ep_irq[2*k +: 2])
        );
    end

endmodule

// File: tb/usb_out_arm_ctrl_tb_top.sv
module usb_out_arm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       tok_valid = 1'b0;
    logic [2:0] tok_ep = '0;
    logic       pkt_end = 1'b0;
    logic       crc_ok = 1'b0;
    logic       tog_ok = 1'b0;
    logic       store_en;
    logic [2:0] store_ep;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_sel = '0;
    logic [2:0] cpu_ep = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] ep_busy;
    logic [7:0] ep_irq;
    logic [5:0] pair_cfg;

    always #5 clk = ~clk;

    usb_out_arm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .pkt_end(pkt_end),
        .crc_ok(crc_ok), .tog_ok(tog_ok),
        .store_en(store_en), .store_ep(store_ep),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_ep(cpu_ep), .cpu_wdata(cpu_wdata),
        .ep_busy(ep_busy), .ep_irq(ep_irq), .pair_cfg(pair_cfg)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit       own_m [8];
    bit       irq_m [8];
    bit       fp_m  [4];
    bit       dp_m  [4];
    bit [5:0] pair_m;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_paired(int ep);
        int k = ep / 2;
        return (k >= 1) && pair_m[k+2];
    endfunction

    function automatic bit m_ready(int ep);
        int k = ep / 2;
        if (ep == 0) return 1'b0;
        if (m_paired(ep)) begin
            if (ep % 2 == 1) return 1'b0;
            return own_m[fp_m[k] ? ep + 1 : ep];
        end
        return own_m[ep];
    endfunction

    function automatic int m_tgt(int ep);
        if (m_paired(ep)) return fp_m[ep/2] ? ep + 1 : ep;
        return ep;
    endfunction

    function automatic logic [7:0] m_busy();
        logic [7:0] v = '0;
        for (int e = 1; e < 8; e++) v[e] = m_ready(e);
        return v;
    endfunction

    function automatic logic [7:0] m_irq();
        logic [7:0] v = '0;
        for (int e = 1; e < 8; e++) v[e] = irq_m[e];
        return v;
    endfunction

    task automatic m_reset_all();
        for (int e = 0; e < 8; e++) begin
            own_m[e] = (e != 0);
            irq_m[e] = 1'b0;
        end
        for (int k = 0; k < 4; k++) begin
            fp_m[k] = 1'b0;
            dp_m[k] = 1'b0;
        end
    endtask

    task automatic check_state(string req);
        chk(ep_busy == m_busy(), req, "ep_busy", int'(ep_busy), int'(m_busy()));
        chk(ep_irq == m_irq(), req, "ep_irq", int'(ep_irq), int'(m_irq()));
        chk(pair_cfg == pair_m, req, "pair_cfg", int'(pair_cfg), int'(pair_m));
    endtask

    task automatic do_pkt(int ep, bit crc, bit tog, string req);
        bit rdy = m_ready(ep);
        int tgt = m_tgt(ep);
        bit good = crc && tog;
        int exp_code;
        bit exp_store = (ep != 0) && rdy;
        if (ep == 0) exp_code = 0;
        else if (rdy) exp_code = good ? 1 : 0;
        else exp_code = good ? 2 : 0;
        @(negedge clk);
        tok_valid = 1'b1;
        tok_ep = 3'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
        chk(store_en == exp_store, req, "store_en", int'(store_en), int'(exp_store));
        if (exp_store)
            chk(store_ep == 3'(tgt), req, "store_ep", int'(store_ep), tgt);
        pkt_end = 1'b1;
        crc_ok = crc;
        tog_ok = tog;
        @(negedge clk);
        pkt_end = 1'b0;
        chk(hs_valid == (exp_code != 0), req, "hs_valid", int'(hs_valid), int'(exp_code != 0));
        chk(hs_code == 2'(exp_code), req, "hs_code", int'(hs_code), exp_code);
        if (exp_store && good) begin
            if (m_paired(ep)) begin
                own_m[tgt] = 1'b0;
                fp_m[ep/2] = ~fp_m[ep/2];
            end else begin
                own_m[ep] = 1'b0;
            end
            irq_m[ep] = 1'b1;
        end
        @(negedge clk);
        chk(hs_valid == 1'b0, "R11", "hs_valid second cycle", int'(hs_valid), 0);
        check_state(req);
    endtask

    task automatic cpu_wr(int sel, int ep, logic [7:0] data, string req);
        @(negedge clk);
        cpu_we = 1'b1;
        cpu_sel = 2'(sel);
        cpu_ep = 3'(ep);
        cpu_wdata = data;
        @(negedge clk);
        cpu_we = 1'b0;
        if (sel == 0) begin
            if (ep != 0) begin
                if (m_paired(ep)) begin
                    if (ep % 2 == 0) begin
                        int d = dp_m[ep/2] ? ep + 1 : ep;
                        if (!own_m[d]) begin
                            own_m[d] = 1'b1;
                            dp_m[ep/2] = ~dp_m[ep/2];
                        end
                    end
                end else begin
                    own_m[ep] = 1'b1;
                end
            end
        end else if (sel == 1) begin
            for (int e = 1; e < 8; e++) if (data[e]) irq_m[e] = 1'b0;
        end else if (sel == 2) begin
            for (int k = 1; k < 4; k++) begin
                if (data[k+2] != pair_m[k+2]) begin
                    own_m[2*k] = 1'b1;
                    own_m[2*k+1] = 1'b1;
                    irq_m[2*k] = 1'b0;
                    irq_m[2*k+1] = 1'b0;
                    fp_m[k] = 1'b0;
                    dp_m[k] = 1'b0;
                end
            end
            pair_m = data[5:0];
        end
        check_state(req);
    endtask

    task automatic bus_rst(string req);
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        m_reset_all();
        check_state(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        m_reset_all();
        pair_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_state("R1");
        chk(store_en == 1'b0, "R1", "store_en", int'(store_en), 0);
        chk(hs_valid == 1'b0, "R1", "hs_valid", int'(hs_valid), 0);

        // R3: armed endpoint accepts
        do_pkt(1, 1, 1, "R3");
        // R4: later token NAKed until re-arm
        do_pkt(1, 1, 1, "R4");
        // R2: unarmed, corrupted packet gets nothing
        do_pkt(1, 0, 1, "R2");
        cpu_wr(0, 1, 8'hA5, "R4");
        // R5: bad CRC and bad toggle keep state
        do_pkt(1, 0, 1, "R5");
        do_pkt(1, 1, 0, "R5");
        do_pkt(1, 1, 1, "R3");
        do_pkt(5, 1, 1, "R3");
        // R6: write-1-to-clear, zeros ignored
        cpu_wr(1, 0, 8'h00, "R6");
        cpu_wr(1, 0, 8'h02, "R6");
        // R7: pair OUT 2/3 and IN 2/3
        cpu_wr(2, 0, 8'h09, "R7");
        // R8: ping-pong fill
        do_pkt(2, 1, 1, "R8");
        do_pkt(2, 1, 1, "R8");
        do_pkt(2, 1, 1, "R8");
        // R9: odd side ignored, even write frees oldest
        cpu_wr(0, 3, 8'h11, "R9");
        do_pkt(3, 1, 1, "R9");
        cpu_wr(0, 2, 8'h00, "R9");
        do_pkt(2, 1, 1, "R9");
        cpu_wr(0, 2, 8'h00, "R9");
        cpu_wr(0, 2, 8'h00, "R9");
        cpu_wr(0, 2, 8'h00, "R9");
        // R10: endpoint 0 untouched
        do_pkt(0, 1, 1, "R10");
        cpu_wr(0, 0, 8'hFF, "R10");
        // R12: bus reset keeps pairing
        do_pkt(2, 1, 1, "R12");
        bus_rst("R12");
        // R7: unpairing clears the pair
        cpu_wr(2, 0, 8'h30, "R7");

        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 55) begin
                do_pkt($urandom_range(0, 7), ($urandom_range(0, 9) != 0),
                       ($urandom_range(0, 9) != 0), "R8");
            end else if (op < 80) begin
                cpu_wr(0, $urandom_range(0, 7), 8'($urandom()), "R4");
            end else if (op < 92) begin
                cpu_wr(1, 0, 8'($urandom()), "R6");
            end else if (op < 98) begin
                cpu_wr(2, 0, 8'($urandom_range(0, 63)), "R7");
            end else begin
                bus_rst("R1");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule